// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital side of a three-input, 10-bit successive-approximation analog-to-digital converter. Software reaches it through a small single-cycle register port: a write strobe with an address and write data, and a read data bus that always shows the register at the current address. Writing the control register with the power bit set and a legal input number starts a conversion. There is no separate start bit. The block first counts a programmable settling time in converter clocks. It then runs a binary search, one bit per clock, against an external comparator. The comparator compares the selected analog input with the trial code that the block drives onto its DAC output.

When the search ends, the block stores the 10-bit code, drops its busy flag and sets a sticky completion flag. This flag drives the interrupt line when the interrupt enable is set. Writing the control register with the power bit clear powers the converter down and, if a conversion is running, abandons it. Writing the control register with the flag bit clear clears the flag, so writing zero does both. The register port has no flow control: every write is accepted in the cycle it is presented, and reads are combinational. No interface of this block carries a valid/ready handshake, so no back-pressure rules apply.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset every register reads zero, the interrupt line is low and the power output is low.
- R2: Register map by byte address. Address 0x00 gives the result in bits [9:0], with all higher bits zero. Address 0x04 gives busy in bit 0. Address 0x08 is control: input number in bits [2:0], power in bit 3, interrupt enable in bit 5, completion flag in bit 6. Address 0x0C holds a 6-bit settling count in bits [5:0].
- R3: A control write with bit 3 set and bits [2:0] in 0..2, made while not busy, starts a conversion. Busy then reads 1 for exactly D+10 cycles, where D is the settling count when the conversion starts.
- R4: The search tests bits from 9 down to 0, one per clock. It keeps a bit when the comparator input reports that the analog level is at or above the trial code. The stored result is therefore the analog level of the converted input, given as a 10-bit code.
- R5: At the end of a conversion the result register updates, busy clears and the completion flag (control bit 6) sets, all on the same clock edge.
- R6: The interrupt output is high exactly while both the completion flag and the interrupt enable are 1.
- R7: A control write with bit 6 at 0 clears the completion flag. A control write with bit 3 at 0 drives the power output low.
- R8: A control write that selects input 3 to 7 starts nothing: busy stays 0 and no interrupt is raised.
- R9: A control write with bit 3 at 0 during a conversion stops it at once. Busy is 0 in the next cycle, the result register keeps its old value and the completion flag is not set.
- R10: Writes to the settling count or to the input number while busy do not change the running conversion. They apply from the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Byte address for both write and read |
| wdata | input | 8 | Write data |
| rd_data | output | 16 | Register selected by addr, combinational |
| cmp_hi | input | 1 | Comparator: analog level at or above dac_code |
| dac_code | output | 10 | Trial code driven to the DAC; zero when idle |
| conv_chan | output | 2 | Input being converted |
| conv_pwr | output | 1 | Converter power enable (control bit 3) |
| irq | output | 1 | Interrupt request |

## Verification
The bench models the comparator as an ideal compare of the selected input level against dac_code. It checks that codes 0, 1023, 511 and 512 come back exactly; a search that compared the wrong way round or skipped a bit would return another code. It counts busy cycles for settling counts of 0 and above, which exposes an off-by-one in the settling counter or an extra trial cycle. It checks three hazards:
- An abort in mid-search must leave the old result and no flag; a design that stored a partial code would fail this.
- Input numbers 3 to 7 must start nothing; a decoder that wrapped the number would start a conversion.
- Settling and input writes made during a busy conversion must apply only to the next one; a design that sampled them live would change the cycle count or the converted input.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam logic [3:0] OFF_RESULT = 4'h0;
  localparam logic [3:0] OFF_STATUS = 4'h4;
  localparam logic [3:0] OFF_CTRL   = 4'h8;
  localparam logic [3:0] OFF_SETTLE = 4'hC;

  localparam int CTL_CH_W  = 3;
  localparam int CTL_PWR   = 3;
  localparam int CTL_IE    = 5;
  localparam int CTL_FLAG  = 6;
endpackage

// File: rtl/sar_regs.sv
module sar_regs import sar_pkg::*; #(
  parameter int RES_W  = 10,
  parameter int NUM_CH = 3,
  parameter int DLY_W  = 6,
  parameter int WD_W   = 8,
  parameter int RD_W   = 16,
  localparam int CHS_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       addr,
  input  logic [WD_W-1:0]  wdata,
  output logic [RD_W-1:0]  rd_data,
  input  logic             busy,
  input  logic             done,
  input  logic [RES_W-1:0] res_in,
  output logic             start,
  output logic             abort,
  output logic [DLY_W-1:0] dly_q,
  output logic [CHS_W-1:0] conv_chan,
  output logic             pwr_q,
  output logic             irq
);
  logic [CTL_CH_W-1:0] chan_q;
  logic                ie_q, flag_q;
  logic [RES_W-1:0]    res_q;
  logic                ctrl_wr, chan_ok;
  logic                unused_wbits;

  assign unused_wbits = ^{wdata[WD_W-1], wdata[4]};
  assign ctrl_wr = wr_en && (addr == OFF_CTRL);
  assign chan_ok = int'(wdata[CTL_CH_W-1:0]) < NUM_CH;
  assign start   = ctrl_wr && wdata[CTL_PWR] && chan_ok && !busy;
  assign abort   = ctrl_wr && !wdata[CTL_PWR] && busy;
  assign irq     = flag_q & ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q    <= '0;
      pwr_q     <= 1'b0;
      ie_q      <= 1'b0;
      flag_q    <= 1'b0;
      dly_q     <= '0;
      res_q     <= '0;
      conv_chan <= '0;
    end else begin
      if (ctrl_wr) begin
        chan_q <= wdata[CTL_CH_W-1:0];
        pwr_q  <= wdata[CTL_PWR];
        ie_q   <= wdata[CTL_IE];
        flag_q <= flag_q & wdata[CTL_FLAG];
      end
      if (done) begin
        flag_q <= 1'b1;
        res_q  <= res_in;
      end
      if (wr_en && addr == OFF_SETTLE) dly_q <= wdata[DLY_W-1:0];
      if (start) conv_chan <= wdata[CHS_W-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (addr)
      OFF_RESULT: rd_data[RES_W-1:0] = res_q;
      OFF_STATUS: rd_data[0] = busy;
      OFF_CTRL: begin
        rd_data[CTL_CH_W-1:0] = chan_q;
        rd_data[CTL_PWR]      = pwr_q;
        rd_data[CTL_IE]       = ie_q;
        rd_data[CTL_FLAG]     = flag_q;
      end
      OFF_SETTLE: rd_data[DLY_W-1:0] = dly_q;
      default: rd_data = '0;
    endcase
  end

  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flag_q);
  p_abort_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> res_q == $past(res_q));
endmodule

// File: rtl/sar_settle.sv
module sar_settle #(
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [DLY_W-1:0] dly,
  output logic             go,
  output logic             active
);
  logic [DLY_W-1:0] cnt;

  assign go = (start && dly == '0) || (active && cnt == DLY_W'(1) && !abort);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (abort) begin
      active <= 1'b0;
    end else if (start && dly != '0) begin
      active <= 1'b1;
      cnt    <= dly;
    end else if (active) begin
      if (cnt == DLY_W'(1)) active <= 1'b0;
      cnt <= cnt - DLY_W'(1);
    end
  end

  p_settle_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !abort && cnt != DLY_W'(1)) |=> (active && cnt == $past(cnt) - DLY_W'(1)));
endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
  parameter int RES_W = 10,
  localparam int IDX_W = $clog2(RES_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             abort,
  input  logic             cmp_hi,
  output logic             active,
  output logic [RES_W-1:0] dac_code,
  output logic             done,
  output logic [RES_W-1:0] res_next
);
  logic [RES_W-1:0] acc, bit_sel;
  logic [IDX_W-1:0] idx;

  for (genvar b = 0; b < RES_W; b++) begin : g_sel
    assign bit_sel[b]  = active && (idx == IDX_W'(b));
    assign res_next[b] = bit_sel[b] ? cmp_hi : acc[b];
  end

  assign dac_code = acc | bit_sel;
  assign done     = active && idx == '0 && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      acc    <= '0;
      idx    <= '0;
    end else if (abort) begin
      active <= 1'b0;
      acc    <= '0;
    end else if (go) begin
      active <= 1'b1;
      acc    <= '0;
      idx    <= IDX_W'(RES_W - 1);
    end else if (active) begin
      acc <= res_next;
      if (idx == '0) begin
        active <= 1'b0;
        acc    <= '0;
      end else begin
        idx <= idx - IDX_W'(1);
      end
    end
  end

  p_bit_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !abort && idx != '0) |=> (active && idx == $past(idx) - IDX_W'(1)));
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !active);
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl import sar_pkg::*; #(
  parameter int RES_W  = 10,
  parameter int NUM_CH = 3,
  parameter int DLY_W  = 6,
  parameter int WD_W   = 8,
  parameter int RD_W   = 16,
  localparam int CHS_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       addr,
  input  logic [WD_W-1:0]  wdata,
  output logic [RD_W-1:0]  rd_data,
  input  logic             cmp_hi,
  output logic [RES_W-1:0] dac_code,
  output logic [CHS_W-1:0] conv_chan,
  output logic             conv_pwr,
  output logic             irq
);
  logic             start, abort, go, settle_act, eng_act, done, busy;
  logic [DLY_W-1:0] dly_q;
  logic [RES_W-1:0] res_next;

  assign busy = settle_act | eng_act;

  sar_regs #(.RES_W(RES_W), .NUM_CH(NUM_CH), .DLY_W(DLY_W), .WD_W(WD_W), .RD_W(RD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .busy(busy), .done(done), .res_in(res_next),
    .start(start), .abort(abort), .dly_q(dly_q), .conv_chan(conv_chan),
    .pwr_q(conv_pwr), .irq(irq)
  );

  sar_settle #(.DLY_W(DLY_W)) u_settle (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .dly(dly_q),
    .go(go), .active(settle_act)
  );

  sar_engine #(.RES_W(RES_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .go(go), .abort(abort), .cmp_hi(cmp_hi),
    .active(eng_act), .dac_code(dac_code), .done(done), .res_next(res_next)
  );

  p_go_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !eng_act);
  p_bad_chan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_CTRL && int'(wdata[2:0]) >= NUM_CH && !busy) |=> !busy);
endmodule

// File: tb/test_sar_seq_ctrl.sv
module test_sar_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_RES = 4'h0, A_STAT = 4'h4, A_CTRL = 4'h8, A_DLY = 4'hC;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, cmp_hi;
  logic [3:0]  addr = 4'h0;
  logic [7:0]  wdata = 8'h0;
  logic [15:0] rd_data;
  logic [9:0]  dac_code;
  logic [1:0]  conv_chan;
  logic        conv_pwr, irq;
  logic [9:0]  vin [3];
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb cmp_hi = (conv_chan < 2'd3) ? (vin[conv_chan] >= dac_code) : 1'b0;

  sar_seq_ctrl i_sar_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .cmp_hi(cmp_hi), .dac_code(dac_code),
    .conv_chan(conv_chan), .conv_pwr(conv_pwr), .irq(irq)
  );

  function automatic int exp_ctrl(int ch, bit pwr, bit ie, bit flag);
    return ch | (int'(pwr) << 3) | (int'(ie) << 5) | (int'(flag) << 6);
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output int v);
    addr = a; #1; v = int'(rd_data);
  endtask

  task automatic busy_len(output int n);
    int v;
    n = 0;
    rd(A_STAT, v);
    while (v == 1 && n < 500) begin
      n++; @(negedge clk); rd(A_STAT, v);
    end
  endtask

  task automatic convert(int ch, int d, bit ie);
    int n, v;
    wr(A_DLY, 8'(d));
    wr(A_CTRL, 8'(exp_ctrl(ch, 1, ie, 0)));
    busy_len(n);
    chk("R3 busy length", n, d + 10);
    rd(A_RES, v);  chk("R4 result", v, int'(vin[ch]));
    rd(A_STAT, v); chk("R5 busy cleared", v, 0);
    rd(A_CTRL, v); chk("R5 flag set", v, exp_ctrl(ch, 1, ie, 1));
    chk("R6 irq", int'(irq), int'(ie));
  endtask

  initial begin
    int v, n, last;
    void'($urandom(32'h1234_5A5A));
    vin[0] = 10'd0; vin[1] = 10'd0; vin[2] = 10'd0;
    repeat (3) @(negedge clk);
    rd(A_RES, v);  chk("R1 result reset", v, 0);
    rd(A_STAT, v); chk("R1 status reset", v, 0);
    rd(A_CTRL, v); chk("R1 ctrl reset", v, 0);
    rd(A_DLY, v);  chk("R1 settle reset", v, 0);
    chk("R1 irq reset", int'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pwr reset", int'(conv_pwr), 0);

    wr(A_DLY, 8'hFF);
    rd(A_DLY, v); chk("R2 settle width", v, 63);

    // directed corners of the search
    vin[0] = 10'd1023; convert(0, 8, 1); wr(A_CTRL, 8'h00);
    vin[1] = 10'd0;    convert(1, 0, 1); wr(A_CTRL, 8'h00);
    vin[2] = 10'd512;  convert(2, 1, 1); wr(A_CTRL, 8'h00);
    vin[0] = 10'd511;  convert(0, 63, 1);
    rd(A_RES, v); chk("R2 upper bits zero", v >> 10, 0);
    wr(A_CTRL, 8'h00);
    chk("R7 irq cleared", int'(irq), 0);
    chk("R7 pwr off", int'(conv_pwr), 0);
    rd(A_CTRL, v); chk("R7 ctrl zero", v, 0);

    // R6: flag without enable, then enable with flag bit kept
    vin[1] = 10'd77; convert(1, 2, 0);
    wr(A_CTRL, 8'(exp_ctrl(1, 0, 1, 1)));
    chk("R6 irq after enable", int'(irq), 1);
    wr(A_CTRL, 8'(exp_ctrl(1, 0, 1, 0)));
    chk("R7 flag write 0", int'(irq), 0);

    // R8: invalid input numbers
    for (int c = 3; c < 8; c++) begin
      wr(A_CTRL, 8'(exp_ctrl(c, 1, 1, 0)));
      repeat (3) @(negedge clk);
      rd(A_STAT, v); chk("R8 no busy", v, 0);
      chk("R8 no irq", int'(irq), 0);
    end
    wr(A_CTRL, 8'h00);

    // R9: abort mid-search
    rd(A_RES, last);
    vin[2] = 10'd900;
    wr(A_DLY, 8'd4);
    wr(A_CTRL, 8'(exp_ctrl(2, 1, 1, 0)));
    repeat (7) @(negedge clk);
    wr(A_CTRL, 8'h00);
    rd(A_STAT, v); chk("R9 busy dropped", v, 0);
    rd(A_RES, v);  chk("R9 result kept", v, last);
    repeat (15) @(negedge clk);
    rd(A_CTRL, v); chk("R9 no flag", v, 0);
    chk("R9 no irq", int'(irq), 0);

    // R10: writes while busy apply next time
    vin[0] = 10'd300; vin[2] = 10'd700;
    wr(A_DLY, 8'd3);
    wr(A_CTRL, 8'(exp_ctrl(0, 1, 1, 0)));
    wr(A_DLY, 8'd20);
    wr(A_CTRL, 8'(exp_ctrl(2, 1, 1, 0)));
    busy_len(n);
    chk("R10 length unchanged", n, 11);
    rd(A_RES, v); chk("R10 input unchanged", v, 300);
    wr(A_CTRL, 8'(exp_ctrl(2, 1, 1, 0)));
    busy_len(n);
    chk("R10 new settle used", n, 30);
    rd(A_RES, v); chk("R10 new input used", v, 700);
    wr(A_CTRL, 8'h00);

    // random conversions
    for (int i = 0; i < 24; i++) begin
      int ch, d;
      ch = int'($urandom % 3);
      d  = int'($urandom % 16);
      vin[ch] = 10'($urandom);
      convert(ch, d, 1);
      wr(A_CTRL, 8'h00);
      chk("R7 random clear", int'(irq), 0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog got 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule